// File: doc/BRIEF.md
# Eight-Function Bitwise Logic Unit

This block takes two operand words of parameterised width and a 3-bit function code, and forms one result word by applying one of eight bitwise functions at every bit position on its own. The functions are the six two-input gates AND, OR, XOR, NAND, NOR and XNOR, plus two single-operand functions: the inverse of the first operand and the inverse of the second operand.

The combinational result is captured into an output register on a rising clock edge while the input strobe is high. An output valid flag goes high in the cycle after such a capture and drops again after one cycle unless another strobe arrives. A synchronous active-high reset clears both the result and the flag.

Top module: `bitlogic_unit`

## Requirements
- R1: Function code 3'b000 yields the bitwise AND of operand A and operand B.
- R2: Function code 3'b001 yields bitwise OR, and 3'b010 yields bitwise XOR.
- R3: Function code 3'b011 yields the bitwise inverse of operand A, and operand B has no effect on the result.
- R4: Function code 3'b100 yields NAND, 3'b101 yields NOR, and 3'b110 yields XNOR.
- R5: Function code 3'b111 yields the bitwise inverse of operand B, and operand A has no effect on the result.
- R6: Each result bit depends only on the operand bits at the same position; the width is set by parameter WIDTH (default 8).
- R7: On a rising edge with in_valid high, res_q takes the function result and out_valid is 1 after that edge; on an edge with in_valid low, res_q keeps its value and out_valid is 0 after that edge.
- R8: A synchronous reset (rst high at a rising edge) sets res_q to all zeros and out_valid to 0, with priority over in_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operands and function code |
| func_sel | input | 3 | Function code |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| res_q | output | WIDTH | Registered result |
| out_valid | output | 1 | High for one cycle after each capture |

## Verification
The hardest situation to show is that the unused operand of the two inverse functions has no effect. A stuck or crossed path might still give the right answer for a single value. The stimulus therefore holds operand A and the code fixed and sweeps operand B through all-zeros, all-ones and alternating patterns, then does the same the other way round, comparing every captured result. Hold behaviour is checked by changing all inputs while the strobe is low and confirming that res_q stays where it was.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

    typedef enum logic [2:0] {
        FN_AND   = 3'b000,
        FN_OR    = 3'b001,
        FN_XOR   = 3'b010,
        FN_NOTA  = 3'b011,
        FN_NAND  = 3'b100,
        FN_NOR   = 3'b101,
        FN_XNOR  = 3'b110,
        FN_NOTB  = 3'b111
    } bl_func_e;

    // Per-bit evaluation of one function code.
    function automatic logic bl_bit(input bl_func_e fn, input logic a, input logic b);
        logic r;
        case (fn)
            FN_AND:  r = a & b;
            FN_OR:   r = a | b;
            FN_XOR:  r = a ^ b;
            FN_NOTA: r = ~a;
            FN_NAND: r = ~(a & b);
            FN_NOR:  r = ~(a | b);
            FN_XNOR: r = ~(a ^ b);
            default: r = ~b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bitlogic_slice.sv
module bitlogic_slice
    import bitlogic_pkg::*;
(
    input  bl_func_e fn,
    input  logic     a,
    input  logic     b,
    output logic     y
);
    always_comb y = bl_bit(fn, a, b);
endmodule

// File: rtl/bitlogic_core.sv
module bitlogic_core
    import bitlogic_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  bl_func_e           fn,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic [WIDTH-1:0]   y
);
    // R6: one independent slice per bit position
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bitlogic_slice u_slice (
            .fn (fn),
            .a  (a[i]),
            .b  (b[i]),
            .y  (y[i])
        );
    end
endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
    import bitlogic_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       func_sel,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] res_q,
    output logic             out_valid
);
    localparam logic [WIDTH-1:0] RES_ZERO = '0;

    bl_func_e         fn;
    logic [WIDTH-1:0] res_d;

    always_comb fn = bl_func_e'(func_sel);

    bitlogic_core #(.WIDTH(WIDTH)) u_core (
        .fn (fn),
        .a  (opa),
        .b  (opb),
        .y  (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= RES_ZERO;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end
endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       func_sel,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] res_q,
    input logic             out_valid
);
    p_and_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_sel == 3'b000) |=> (res_q == ($past(opa) & $past(opb))));
    p_xor_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_sel == 3'b010) |=> (res_q == ($past(opa) ^ $past(opb))));
    p_nota_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_sel == 3'b011) |=> (res_q == ~$past(opa)));
    p_nor_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_sel == 3'b101) |=> (res_q == ~($past(opa) | $past(opb))));
    p_notb_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && func_sel == 3'b111) |=> (res_q == ~$past(opb)));
    p_valid_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_q)));
    p_reset_r8: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !out_valid));
endmodule

bind bitlogic_unit bitlogic_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .func_sel  (func_sel),
    .opa       (opa),
    .opb       (opb),
    .res_q     (res_q),
    .out_valid (out_valid)
);

// File: tb/bitlogic_unit_tb_top.sv
`timescale 1ns/1ps
module bitlogic_unit_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [2:0]   func_sel = 3'b000;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] res_q;
    logic         out_valid;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    bitlogic_unit #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func_sel(func_sel),
        .opa(opa), .opb(opb), .res_q(res_q), .out_valid(out_valid)
    );

    function automatic logic [W-1:0] model(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
        case (f)
            3'b000: return a & b;
            3'b001: return a | b;
            3'b010: return a ^ b;
            3'b011: return ~a;
            3'b100: return ~(a & b);
            3'b101: return ~(a | b);
            3'b110: return ~(a ^ b);
            default: return ~b;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, capture at next posedge, sample at following negedge.
    task automatic apply(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        @(negedge clk);
        func_sel = f; opa = a; opb = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, res_q, model(f, a, b));
        check({req, " valid"}, {{(W-1){1'b0}}, out_valid}, 1);
    endtask

    task automatic t_reset;
        check("R8 reset result", res_q, '0);
        check("R8 reset valid", {{(W-1){1'b0}}, out_valid}, 0);
    endtask

    task automatic t_two_input;
        logic [W-1:0] pa [4] = '{8'hF0, 8'hA5, 8'h00, 8'hFF};
        logic [W-1:0] pb [4] = '{8'hCC, 8'h5A, 8'hFF, 8'h3C};
        for (int k = 0; k < 4; k++) begin
            apply(3'b000, pa[k], pb[k], "R1 AND");
            apply(3'b001, pa[k], pb[k], "R2 OR");
            apply(3'b010, pa[k], pb[k], "R2 XOR");
            apply(3'b100, pa[k], pb[k], "R4 NAND");
            apply(3'b101, pa[k], pb[k], "R4 NOR");
            apply(3'b110, pa[k], pb[k], "R4 XNOR");
        end
    endtask

    task automatic t_ignore;
        logic [W-1:0] sw [4] = '{8'h00, 8'hFF, 8'hAA, 8'h55};
        for (int k = 0; k < 4; k++) begin
            apply(3'b011, 8'h3C, sw[k], "R3 NOTA ignores B");
            apply(3'b111, sw[k], 8'h96, "R5 NOTB ignores A");
        end
    endtask

    task automatic t_bits;
        // R6: walking one on A against all-ones B under XOR
        for (int i = 0; i < W; i++)
            apply(3'b010, 8'h01 << i, 8'hFF, "R6 bit independence");
    endtask

    task automatic t_hold;
        logic [W-1:0] prev;
        apply(3'b000, 8'hE7, 8'h7E, "R7 capture");
        prev = res_q;
        @(negedge clk);
        func_sel = 3'b111; opa = 8'h12; opb = 8'h34; in_valid = 1'b0;
        @(negedge clk);
        check("R7 hold result", res_q, prev);
        check("R7 valid low", {{(W-1){1'b0}}, out_valid}, 0);
        // back-to-back strobes keep valid high
        @(negedge clk);
        func_sel = 3'b001; opa = 8'h01; opb = 8'h02; in_valid = 1'b1;
        @(negedge clk);
        func_sel = 3'b011; opa = 8'h0F;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 back-to-back result", res_q, 8'hF0);
        check("R7 back-to-back valid", {{(W-1){1'b0}}, out_valid}, 1);
    endtask

    task automatic t_reset_prio;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; func_sel = 3'b001; opa = 8'hFF; opb = 8'hFF;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        check("R8 reset over strobe result", res_q, '0);
        check("R8 reset over strobe valid", {{(W-1){1'b0}}, out_valid}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_two_input();
        t_ignore();
        t_bits();
        t_hold();
        t_reset_prio();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule